// File: doc/BRIEF.md
# Supply Margining Trim Controller

This block is the digital loop that moves a regulator's output to a stored target voltage and holds it there. It drives the code of an 8-bit trim DAC and the enable of the trim output buffer. It reads voltages through an external ADC with a request/valid handshake and a select line. The select picks either the voltage on the idle trim pin or the monitored supply. When no margin is requested, the trim buffer stays disabled and the regulator runs at its own set point.

A margin request comes from a 2-bit register command or from two active-high request pins. Each path has its own enable bit. After the request, a programmable start delay runs. The loop then seeds the DAC from one sample of the undriven trim pin, so the regulator sees no step when the buffer turns on. From there the code creeps one step per update tick until the supply reading matches the selected target. The block then holds the code and raises a done bit and a READY level. A configuration bit sets whether a higher trim voltage raises the output or lowers it.

Top module: `trim_margin_ctrl`

## Requirements
- R1: While no margin is active (after reset, after an Off command, or after the active request pin is released), trim_en_o is low and no ADC request is made. An Off event clears trim_en_o, done_o and ready_o on the next clock edge.
- R2: Register command codes are 00 Off, 01 nominal, 10 margin high and 11 margin low. A register command takes effect only when reg_en_i is high. With pin_en_i high, up pin alone requests margin high, down pin alone requests margin low, and both pins or neither pin means Off. With pin_en_i low, the pins have no effect.
- R3: After a command that starts from idle, the first ADC request comes after exactly 5, 10, 20 or 35 delay ticks, for dly_sel_i = 0, 1, 2 or 3. A delay tick is counted only if it is seen on a clock edge after the command edge.
- R4: The first ADC request of a fresh margin cycle has adc_sel_o = 0 (trim pin). The DAC code is loaded with the upper 8 bits of that sample. trim_en_o rises on the edge that takes in that sample and at no earlier point.
- R5: After seeding, each update tick starts one supply sample with adc_sel_o = 1. Each sample that does not match moves the code by exactly one. A match means |reading − 4·target| < 4 for the default 10-bit ADC.
- R6: With neg_trim_i = 0, a reading below target increments the code. With neg_trim_i = 1, a reading below target decrements it. A reading above target moves the code the opposite way.
- R7: On a match, the code is frozen and done_o and ready_o go high. They stay high until the next command event.
- R8: The code saturates at 0x00 and 0xFF and never wraps. If the target cannot be reached, trim_en_o stays high and done_o stays low.
- R9: A non-Off command that arrives while trim_en_o is high restarts the delay. The trim output stays enabled, done_o drops, the DAC is not re-seeded, and the loop then steps toward the new target.
- R10: If a pin request change and an enabled register write fall on the same clock edge, the pin request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_tick_i | input | 1 | One-cycle pulse per loop update period |
| dly_tick_i | input | 1 | One-cycle pulse per start-delay unit (0.5 ms nominal) |
| dly_sel_i | input | 2 | Start-delay choice |
| pin_en_i | input | 1 | Enables pin-driven requests |
| reg_en_i | input | 1 | Enables register-driven commands |
| neg_trim_i | input | 1 | 1: higher trim voltage lowers the supply |
| up_pin_i | input | 1 | Margin-high request pin, active high |
| dn_pin_i | input | 1 | Margin-low request pin, active high |
| cmd_wr_i | input | 1 | Strobe for cmd_i |
| cmd_i | input | 2 | Register command code |
| tgt_nom_i | input | 8 | Nominal target |
| tgt_high_i | input | 8 | Margin-high target |
| tgt_low_i | input | 8 | Margin-low target |
| adc_req_o | output | 1 | ADC conversion request, held until valid |
| adc_sel_o | output | 1 | 0: trim pin, 1: monitored supply |
| adc_valid_i | input | 1 | ADC result strobe |
| adc_data_i | input | ADC_W | ADC result |
| dac_code_o | output | 8 | Trim DAC code |
| trim_en_o | output | 1 | Trim output buffer enable |
| ready_o | output | 1 | Supply is at the margin target |
| done_o | output | 1 | Margin-reached status bit |

## Verification
Two things can fall on the same clock edge: a change of the request pins and an enabled register write. The arbiter has to pick one of them. The bench forces this case by raising the up pin and writing a margin-low command on the same falling edge. It judges the result by the code the loop settles at, which must be the margin-high target and not the margin-low one. A second overlap comes from a new command that lands while the loop is holding. Here the bench watches that trim_en_o never drops, that no trim-pin sample is taken, and that done_o falls at once.

// File: rtl/trim_margin_pkg.sv
package trim_margin_pkg;

    localparam int TM_DAC_W = 8;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_NOM  = 2'b01,
        MODE_HIGH = 2'b10,
        MODE_LOW  = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DELAY,
        ST_SEED,
        ST_WAIT,
        ST_MEAS,
        ST_HOLD
    } state_e;

    typedef struct packed {
        state_e                state;
        mode_e                 mode;
        logic [TM_DAC_W-1:0]   code;
        logic                  trim_en;
        logic                  done;
    } ctrl_s;

endpackage

// File: rtl/trim_cmd_arb.sv
module trim_cmd_arb
    import trim_margin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_en_i,
    input  logic       reg_en_i,
    input  logic       up_pin_i,
    input  logic       dn_pin_i,
    input  logic       cmd_wr_i,
    input  logic [1:0] cmd_i,
    output logic       ev_o,
    output mode_e      mode_o
);

    mode_e pin_req;
    mode_e pin_d, pin_q;
    logic  pin_chg;
    logic  reg_hit;

    always_comb begin
        pin_req = MODE_OFF;
        if (pin_en_i) begin
            if (up_pin_i && !dn_pin_i)
                pin_req = MODE_HIGH;
            else if (dn_pin_i && !up_pin_i)
                pin_req = MODE_LOW;
        end
        pin_d   = pin_req;
        pin_chg = (pin_req != pin_q);
        reg_hit = cmd_wr_i && reg_en_i;
        ev_o    = pin_chg || reg_hit;
        // pin changes take precedence over a same-edge register write
        mode_o  = pin_chg ? pin_req : mode_e'(cmd_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pin_q <= MODE_OFF;
        else
            pin_q <= pin_d;
    end

    // R2
    pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_en_i && !$past(pin_en_i) && !cmd_wr_i) |-> !ev_o);

endmodule

// File: rtl/trim_dly_timer.sv
module trim_dly_timer #(
    parameter int U0 = 5,
    parameter int U1 = 10,
    parameter int U2 = 20,
    parameter int U3 = 35
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       run_i,
    input  logic       tick_i,
    input  logic [1:0] sel_i,
    output logic       expired_o
);

    localparam int M01  = (U0 > U1) ? U0 : U1;
    localparam int M23  = (U2 > U3) ? U2 : U3;
    localparam int MAXU = (M01 > M23) ? M01 : M23;
    localparam int CW   = $clog2(MAXU + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s          d, q;
    logic [CW-1:0] lim;

    always_comb begin
        case (sel_i)
            2'd0:    lim = CW'(U0);
            2'd1:    lim = CW'(U1);
            2'd2:    lim = CW'(U2);
            default: lim = CW'(U3);
        endcase
        d = q;
        if (clr_i)
            d.cnt = '0;
        else if (run_i && tick_i && (q.cnt < lim))
            d.cnt = q.cnt + 1'b1;
        expired_o = run_i && (q.cnt >= lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(MAXU));

    // R3
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (q.cnt == '0));

endmodule

// File: rtl/trim_step_calc.sv
module trim_step_calc
    import trim_margin_pkg::*;
#(
    parameter int ADC_W = 10
) (
    input  logic [TM_DAC_W-1:0] code_i,
    input  logic [TM_DAC_W-1:0] target_i,
    input  logic [ADC_W-1:0]    meas_i,
    input  logic                neg_i,
    output logic                eq_o,
    output logic [TM_DAC_W-1:0] next_o
);

    localparam int SH = ADC_W - TM_DAC_W;
    localparam int EW = ADC_W + 2;

    logic [EW-1:0]        tgt_ext;
    logic signed [EW-1:0] diff;
    logic [EW-1:0]        mag;
    logic                 below;
    logic                 go_up;

    always_comb begin
        tgt_ext = EW'(target_i) << SH;
        diff    = $signed({2'b00, meas_i}) - $signed(tgt_ext);
        mag     = diff[EW-1] ? $unsigned(-diff) : $unsigned(diff);
        eq_o    = mag < (EW'(1) << SH);
        below   = diff[EW-1];
        go_up   = below ^ neg_i;
        next_o  = code_i;
        if (!eq_o) begin
            if (go_up) begin
                if (code_i != {TM_DAC_W{1'b1}})
                    next_o = code_i + 1'b1;
            end else begin
                if (code_i != '0)
                    next_o = code_i - 1'b1;
            end
        end
    end

endmodule

// File: rtl/trim_margin_ctrl.sv
module trim_margin_ctrl
    import trim_margin_pkg::*;
#(
    parameter int ADC_W  = 10,
    parameter int DLY_U0 = 5,
    parameter int DLY_U1 = 10,
    parameter int DLY_U2 = 20,
    parameter int DLY_U3 = 35
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upd_tick_i,
    input  logic                dly_tick_i,
    input  logic [1:0]          dly_sel_i,
    input  logic                pin_en_i,
    input  logic                reg_en_i,
    input  logic                neg_trim_i,
    input  logic                up_pin_i,
    input  logic                dn_pin_i,
    input  logic                cmd_wr_i,
    input  logic [1:0]          cmd_i,
    input  logic [TM_DAC_W-1:0] tgt_nom_i,
    input  logic [TM_DAC_W-1:0] tgt_high_i,
    input  logic [TM_DAC_W-1:0] tgt_low_i,
    output logic                adc_req_o,
    output logic                adc_sel_o,
    input  logic                adc_valid_i,
    input  logic [ADC_W-1:0]    adc_data_i,
    output logic [TM_DAC_W-1:0] dac_code_o,
    output logic                trim_en_o,
    output logic                ready_o,
    output logic                done_o
);

    ctrl_s                d, q;
    logic                 arb_ev;
    mode_e                arb_mode;
    logic                 dly_expired;
    logic [TM_DAC_W-1:0]  target;
    logic                 meas_eq;
    logic [TM_DAC_W-1:0]  step_code;

    trim_cmd_arb u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_en_i (pin_en_i),
        .reg_en_i (reg_en_i),
        .up_pin_i (up_pin_i),
        .dn_pin_i (dn_pin_i),
        .cmd_wr_i (cmd_wr_i),
        .cmd_i    (cmd_i),
        .ev_o     (arb_ev),
        .mode_o   (arb_mode)
    );

    trim_dly_timer #(
        .U0 (DLY_U0),
        .U1 (DLY_U1),
        .U2 (DLY_U2),
        .U3 (DLY_U3)
    ) u_dly (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (arb_ev),
        .run_i     (q.state == ST_DELAY),
        .tick_i    (dly_tick_i),
        .sel_i     (dly_sel_i),
        .expired_o (dly_expired)
    );

    trim_step_calc #(
        .ADC_W (ADC_W)
    ) u_step (
        .code_i   (q.code),
        .target_i (target),
        .meas_i   (adc_data_i),
        .neg_i    (neg_trim_i),
        .eq_o     (meas_eq),
        .next_o   (step_code)
    );

    always_comb begin
        case (q.mode)
            MODE_HIGH: target = tgt_high_i;
            MODE_LOW:  target = tgt_low_i;
            default:   target = tgt_nom_i;
        endcase
    end

    always_comb begin
        d = q;
        case (q.state)
            ST_IDLE: ;
            ST_DELAY: begin
                if (dly_expired)
                    d.state = q.trim_en ? ST_WAIT : ST_SEED;
            end
            ST_SEED: begin
                if (adc_valid_i) begin
                    d.code    = adc_data_i[ADC_W-1 -: TM_DAC_W];
                    d.trim_en = 1'b1;
                    d.state   = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (upd_tick_i)
                    d.state = ST_MEAS;
            end
            ST_MEAS: begin
                if (adc_valid_i) begin
                    if (meas_eq) begin
                        d.state = ST_HOLD;
                        d.done  = 1'b1;
                    end else begin
                        d.code  = step_code;
                        d.state = ST_WAIT;
                    end
                end
            end
            ST_HOLD: ;
            default: d.state = ST_IDLE;
        endcase
        if (arb_ev) begin
            d.mode = arb_mode;
            d.done = 1'b0;
            if (arb_mode == MODE_OFF) begin
                d.state   = ST_IDLE;
                d.trim_en = 1'b0;
            end else begin
                d.state = ST_DELAY;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state   <= ST_IDLE;
            q.mode    <= MODE_OFF;
            q.code    <= '0;
            q.trim_en <= 1'b0;
            q.done    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign adc_req_o  = (q.state == ST_SEED) || (q.state == ST_MEAS);
    assign adc_sel_o  = (q.state == ST_MEAS);
    assign dac_code_o = q.code;
    assign trim_en_o  = q.trim_en;
    assign done_o     = q.done;
    assign ready_o    = (q.state == ST_HOLD);

    // R1
    off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_ev && arb_mode == MODE_OFF) |=> (!trim_en_o && !done_o && !ready_o));

    // R4
    seed_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trim_en_o) |-> $past(adc_valid_i && adc_req_o && !adc_sel_o));

    // R5
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_en_o && $past(trim_en_o)) |->
            (({1'b0, dac_code_o}) == ({1'b0, $past(dac_code_o)}) ||
             ({1'b0, dac_code_o}) == ({1'b0, $past(dac_code_o)} + 9'd1) ||
             ({1'b0, dac_code_o} + 9'd1) == ({1'b0, $past(dac_code_o)})));

    // R5
    sel_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_req_o && $past(adc_req_o) && !$past(adc_valid_i)) |-> $stable(adc_sel_o));

    // R7
    hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(done_o)) |-> $stable(dac_code_o));

    // R8
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_en_o && $past(trim_en_o) && $past(dac_code_o) == 8'hFF) |-> (dac_code_o != 8'h00));

    // R9
    keep_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_en_o && arb_ev && arb_mode != MODE_OFF) |=> (trim_en_o && !done_o));

endmodule

// File: tb/trim_margin_ctrl_tb_top.sv
module trim_margin_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd_tick_i = 1'b0;
    logic       dly_tick_i = 1'b0;
    logic [1:0] dly_sel_i = 2'd0;
    logic       pin_en_i = 1'b0;
    logic       reg_en_i = 1'b0;
    logic       neg_trim_i = 1'b0;
    logic       up_pin_i = 1'b0;
    logic       dn_pin_i = 1'b0;
    logic       cmd_wr_i = 1'b0;
    logic [1:0] cmd_i = 2'd0;
    logic [7:0] tgt_nom_i = 8'h00;
    logic [7:0] tgt_high_i = 8'h00;
    logic [7:0] tgt_low_i = 8'h00;
    logic       adc_req_o;
    logic       adc_sel_o;
    logic       adc_valid_i = 1'b0;
    logic [9:0] adc_data_i = 10'd0;
    logic [7:0] dac_code_o;
    logic       trim_en_o;
    logic       ready_o;
    logic       done_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    trim_margin_ctrl dut_i (
        .clk (clk), .rst_n (rst_n),
        .upd_tick_i (upd_tick_i), .dly_tick_i (dly_tick_i), .dly_sel_i (dly_sel_i),
        .pin_en_i (pin_en_i), .reg_en_i (reg_en_i), .neg_trim_i (neg_trim_i),
        .up_pin_i (up_pin_i), .dn_pin_i (dn_pin_i),
        .cmd_wr_i (cmd_wr_i), .cmd_i (cmd_i),
        .tgt_nom_i (tgt_nom_i), .tgt_high_i (tgt_high_i), .tgt_low_i (tgt_low_i),
        .adc_req_o (adc_req_o), .adc_sel_o (adc_sel_o),
        .adc_valid_i (adc_valid_i), .adc_data_i (adc_data_i),
        .dac_code_o (dac_code_o), .trim_en_o (trim_en_o),
        .ready_o (ready_o), .done_o (done_o)
    );

    // ---------------- plant and ADC model ----------------
    int         plant_off = 0;
    logic [9:0] pin_val = 10'h200;
    bit         adc_busy = 0;
    int         adc_lat = 0;
    int         cyc = 0;

    function automatic logic [9:0] plant(input logic [7:0] code, input logic neg);
        int v;
        v = neg ? 4 * (255 - int'(code)) : 4 * int'(code);
        v = v + plant_off;
        if (v < 0) v = 0;
        if (v > 1023) v = 1023;
        return 10'(v);
    endfunction

    always @(negedge clk) begin
        cyc++;
        upd_tick_i = (cyc % 4 == 0);
        dly_tick_i = (cyc % 2 == 0);
        if (adc_valid_i) begin
            adc_valid_i = 1'b0;
        end else if (adc_busy) begin
            adc_lat--;
            if (adc_lat == 0) begin
                adc_busy    = 0;
                adc_valid_i = 1'b1;
                adc_data_i  = adc_sel_o ? plant(dac_code_o, neg_trim_i) : pin_val;
            end
        end else if (adc_req_o) begin
            adc_busy = 1;
            adc_lat  = 3;
        end
    end

    // ---------------- observation flags ----------------
    logic [7:0] prev_code = 8'h00;
    logic       prev_en = 1'b0;
    logic [7:0] first_code = 8'h00;
    int         step_viol = 0;
    bit         en_dropped = 0;
    bit         seen_req = 0;
    bit         seen_seed = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_en && trim_en_o) begin
                if (!(dac_code_o == prev_code || dac_code_o == prev_code + 8'd1 && prev_code != 8'hFF ||
                      dac_code_o == prev_code - 8'd1 && prev_code != 8'h00))
                    step_viol++;
            end
            if (!prev_en && trim_en_o) first_code = dac_code_o;
            if (!trim_en_o) en_dropped = 1;
            if (adc_req_o) seen_req = 1;
            if (adc_req_o && !adc_sel_o) seen_seed = 1;
        end
        prev_code = dac_code_o;
        prev_en   = trim_en_o;
    end

    task automatic clr_flags();
        #1;
        en_dropped = 0;
        seen_req   = 0;
        seen_seed  = 0;
    endtask

    // ---------------- delay tick counter ----------------
    int dly_cnt = 0;
    bit cnt_en = 0;
    always @(posedge clk) if (cnt_en && dly_tick_i) dly_cnt++;

    // ---------------- scoreboard ----------------
    typedef struct {
        string      tag;
        bit         care_code;
        logic [7:0] code;
        logic       en;
        logic       done;
    } exp_t;
    exp_t sbq[$];

    task automatic expect_out(input string tag, input bit care, input logic [7:0] code,
                              input logic en, input logic done);
        exp_t e;
        @(posedge clk);
        #1;
        e.tag = tag; e.care_code = care; e.code = code; e.en = en; e.done = done;
        sbq.push_back(e);
    endtask

    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            checks++;
            if ((e.care_code && dac_code_o != e.code) || trim_en_o != e.en ||
                done_o != e.done || ready_o != e.done) begin
                fails++;
                $display("FAIL %s: code=%0h en=%0b done=%0b ready=%0b exp code=%0h en=%0b done=%0b",
                         e.tag, dac_code_o, trim_en_o, done_o, ready_o, e.code, e.en, e.done);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // ---------------- driver tasks ----------------
    task automatic reg_cmd(input logic [1:0] c);
        @(negedge clk);
        cmd_i = c;
        cmd_wr_i = 1'b1;
        @(negedge clk);
        cmd_wr_i = 1'b0;
    endtask

    // called at the first falling edge after the command edge
    task automatic count_delay(input int exp, input string tag);
        int n;
        dly_cnt = 0;
        cnt_en  = 1;
        n = 0;
        while (!adc_req_o && n < 3000) begin
            @(negedge clk);
            n++;
        end
        cnt_en = 0;
        chk(dly_cnt == exp, tag, dly_cnt, exp);
    endtask

    task automatic wait_done(input string tag);
        bit ok;
        ok = 0;
        for (int n = 0; n < 8000; n++) begin
            @(negedge clk);
            if (done_o) begin
                ok = 1;
                break;
            end
        end
        chk(ok, tag, int'(ok), 1);
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: act=expired exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        wait_cycles(5);
        rst_n = 1'b1;

        // R1 reset state
        expect_out("R1 reset", 1, 8'h00, 0, 0);
        @(negedge clk);
        chk(adc_req_o == 1'b0, "R1 no request after reset", int'(adc_req_o), 0);

        // R3 R4 R5 R7: register margin high from idle
        reg_en_i = 1; dly_sel_i = 2'd0; tgt_high_i = 8'h90; pin_val = 10'h200;
        reg_cmd(2'b10);
        count_delay(5, "R3 delay sel0");
        chk(trim_en_o == 1'b0 && adc_sel_o == 1'b0, "R4 seed sample before enable",
            int'({trim_en_o, adc_sel_o}), 0);
        wait_done("R7 high reached");
        chk(first_code == 8'h80, "R4 seeded code", first_code, 8'h80);
        expect_out("R7 hold high", 1, 8'h90, 1, 1);
        chk(step_viol == 0, "R5 one step per sample", step_viol, 0);

        // R9 restart while holding
        dly_sel_i = 2'd1; tgt_low_i = 8'h70;
        clr_flags();
        reg_cmd(2'b11);
        chk(done_o == 1'b0 && trim_en_o == 1'b1, "R9 done cleared, drive kept",
            int'({done_o, trim_en_o}), 1);
        wait_done("R9 low reached");
        expect_out("R9 hold low", 1, 8'h70, 1, 1);
        chk(!en_dropped && !seen_seed, "R9 no release, no reseed",
            int'({en_dropped, seen_seed}), 0);

        // R1 off command
        reg_cmd(2'b00);
        expect_out("R1 off", 0, 8'h00, 0, 0);
        clr_flags();
        wait_cycles(80);
        chk(!seen_req, "R1 idle makes no request", int'(seen_req), 0);

        // R2 register path disabled
        reg_en_i = 0;
        clr_flags();
        reg_cmd(2'b10);
        wait_cycles(120);
        expect_out("R2 register disabled", 0, 8'h00, 0, 0);
        chk(!seen_req, "R2 disabled register no request", int'(seen_req), 0);
        reg_en_i = 1;

        // R6 negative trim toward nominal
        neg_trim_i = 1; tgt_nom_i = 8'h60; dly_sel_i = 2'd2;
        reg_cmd(2'b01);
        count_delay(20, "R3 delay sel2");
        wait_done("R6 negative reached");
        expect_out("R6 negative hold", 1, 8'h9F, 1, 1);
        reg_cmd(2'b00);
        neg_trim_i = 0;

        // R2 pin path: up pin
        reg_en_i = 0; pin_en_i = 1; dly_sel_i = 2'd3; tgt_high_i = 8'h88;
        @(negedge clk);
        up_pin_i = 1;
        @(negedge clk);
        count_delay(35, "R3 delay sel3");
        wait_done("R2 up pin reached");
        expect_out("R2 up pin hold", 1, 8'h88, 1, 1);
        @(negedge clk);
        up_pin_i = 0;
        expect_out("R1 pin release", 0, 8'h00, 0, 0);

        // R2 down pin, then both pins
        dly_sel_i = 2'd0; tgt_low_i = 8'h78;
        @(negedge clk);
        dn_pin_i = 1;
        wait_done("R2 down pin reached");
        expect_out("R2 down pin hold", 1, 8'h78, 1, 1);
        @(negedge clk);
        up_pin_i = 1;
        expect_out("R2 both pins is off", 0, 8'h00, 0, 0);
        @(negedge clk);
        up_pin_i = 0; dn_pin_i = 0;
        wait_cycles(60);

        // R2 pins disabled
        pin_en_i = 0;
        clr_flags();
        @(negedge clk);
        up_pin_i = 1;
        wait_cycles(120);
        expect_out("R2 pins disabled", 0, 8'h00, 0, 0);
        chk(!seen_req, "R2 disabled pins no request", int'(seen_req), 0);
        @(negedge clk);
        up_pin_i = 0;

        // R5 equality tolerance
        reg_en_i = 1; plant_off = 3; tgt_high_i = 8'h90;
        reg_cmd(2'b10);
        wait_done("R5 tolerance reached");
        expect_out("R5 tolerance hold", 1, 8'h8F, 1, 1);
        reg_cmd(2'b00);

        // R8 saturation high
        plant_off = -40; tgt_high_i = 8'hFF; pin_val = 10'h3F0;
        reg_cmd(2'b10);
        wait_cycles(400);
        expect_out("R8 top rail", 1, 8'hFF, 1, 0);
        chk(step_viol == 0, "R8 no wrap at top", step_viol, 0);
        reg_cmd(2'b00);

        // R8 saturation low
        plant_off = 40; tgt_low_i = 8'h00; pin_val = 10'h00C;
        reg_cmd(2'b11);
        wait_cycles(400);
        expect_out("R8 bottom rail", 1, 8'h00, 1, 0);
        chk(step_viol == 0, "R8 no wrap at bottom", step_viol, 0);
        reg_cmd(2'b00);

        // R10 pin change and register write on the same edge
        plant_off = 0; pin_val = 10'h200; pin_en_i = 1;
        tgt_high_i = 8'h90; tgt_low_i = 8'h70;
        @(negedge clk);
        up_pin_i = 1; cmd_i = 2'b11; cmd_wr_i = 1;
        @(negedge clk);
        cmd_wr_i = 0;
        wait_done("R10 collision reached");
        expect_out("R10 pin wins", 1, 8'h90, 1, 1);
        @(negedge clk);
        up_pin_i = 0;
        wait_cycles(4);

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule